// File: doc/BRIEF.md
# Binary32 to Integer Converter

This block turns a single-precision floating-point operand into a 32-bit integer in one combinational step. A select input chooses whether the result is signed (two's complement) or unsigned. The fraction that is dropped is rounded under a 2-bit rounding mode. A separate truncate control forces rounding toward zero whatever the mode input says, which serves conversion flavours that always truncate.

Next to the integer, the block gives three flags. Invalid marks a result that could not be represented and was replaced by a saturated or zero value. Inexact marks a dropped fraction that was not zero. Input-denormal marks a subnormal operand. Results that cannot be represented follow a fixed saturation policy, so that software sees the same value for every NaN, infinity and out-of-range input of a given sign.

Top module: `f2i_convert`

## Requirements
- R1: An operand of +0 or -0 gives 0 with the invalid, inexact and denormal flags all clear, in both modes.
- R2: An operand whose exponent field is 0 and whose fraction is nonzero raises the denormal flag, and its result follows the small-magnitude rules of R9.
- R3: A NaN operand (exponent field all ones, fraction nonzero) raises invalid and gives 0xFFFFFFFF in unsigned mode and 0 in signed mode, whatever its sign bit.
- R4: A non-NaN operand with a biased exponent of 159 or more, infinities included, raises invalid and no inexact. Unsigned mode gives 0 for a negative operand and 0xFFFFFFFF for a positive one. Signed mode gives 0x80000000 for a negative operand and 0x7FFFFFFF for a positive one.
- R5: For biased exponents 126 to 158, the magnitude is split into an integer and a dropped fraction. The integer is incremented according to rnd_mode: 2'b00 nearest with ties to even, 2'b01 toward +infinity, 2'b10 toward -infinity, 2'b11 toward zero.
- R6: In unsigned mode, a negative operand whose rounded magnitude is nonzero gives 0 with invalid. A negative operand that rounds to 0 gives 0 without invalid.
- R7: In signed mode, a rounded magnitude above 0x7FFFFFFF (positive) or 0x80000000 (negative) clamps to that bound with invalid. Otherwise the result is the magnitude, negated when the sign bit is set.
- R8: Inexact is raised when the dropped fraction is nonzero and the result was not replaced by a clamp. The only case with both flags set is R9's unsigned negative result under rounding toward -infinity.
- R9: A nonzero operand with a biased exponent below 126 gives 0 with inexact. The exceptions are rounding toward +infinity on a positive operand, which gives 1, and rounding toward -infinity on a negative operand, which gives 0xFFFFFFFF (-1) in signed mode and 0 with invalid in unsigned mode.
- R10: With force_trunc high, the result and flags equal those for rnd_mode 2'b11, whatever rnd_mode holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_bits | input | 32 | Binary32 operand: sign at bit 31, exponent field at bits 30:23, fraction at 22:0 |
| want_signed | input | 1 | 1 selects a signed result, 0 an unsigned one |
| rnd_mode | input | 2 | Rounding mode, encoded as in R5 |
| force_trunc | input | 1 | 1 forces rounding toward zero |
| int_out | output | 32 | Converted integer |
| flag_invalid | output | 1 | Result not representable; value saturated or zeroed |
| flag_inexact | output | 1 | Nonzero fraction dropped |
| flag_denorm | output | 1 | Operand is subnormal |

## Verification
Invalid and inexact can fall in the same evaluation in only one case. A tiny negative value converted unsigned while rounding toward -infinity raises both. The random stream draws exponents around 126, random signs and every rounding mode, so this pairing comes up often. The checker flags any pairing of the two flags outside that case, and the bench compares both flags against its model. The denormal flag together with a directed rounding that turns a subnormal into 1 or -1 is provoked directly and judged the same way.

// File: rtl/f2i_pkg.sv
package f2i_pkg;

  // Rounding mode encoding on the rnd_mode input
  typedef enum logic [1:0] {
    RM_NEAREST = 2'b00,
    RM_POS     = 2'b01,
    RM_NEG     = 2'b10,
    RM_ZERO    = 2'b11
  } rmode_e;

  // Operand class decoded from the exponent and fraction fields
  typedef struct packed {
    logic is_zero;
    logic is_sub;
    logic is_inf;
    logic is_nan;
  } fclass_t;

endpackage

// File: rtl/f2i_classify.sv
module f2i_classify #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] op_bits,
  output f2i_pkg::fclass_t      cls,
  output logic                  op_neg,
  output logic [EXP_W-1:0]      exp_f,
  output logic [FRAC_W:0]       sig
);
  localparam int IN_W = 1 + EXP_W + FRAC_W;

  logic [FRAC_W-1:0] frac_f;
  logic              exp_max;
  logic              exp_nil;
  logic              frac_any;

  assign op_neg   = op_bits[IN_W-1];
  assign exp_f    = op_bits[IN_W-2:FRAC_W];
  assign frac_f   = op_bits[FRAC_W-1:0];
  assign exp_max  = &exp_f;
  assign exp_nil  = ~|exp_f;
  assign frac_any = |frac_f;

  always_comb begin
    cls.is_nan  = exp_max & frac_any;
    cls.is_inf  = exp_max & ~frac_any;
    cls.is_zero = exp_nil & ~frac_any;
    cls.is_sub  = exp_nil & frac_any;
  end

  // hidden bit joins the fraction for normal operands
  assign sig = {~exp_nil, frac_f};
endmodule

// File: rtl/f2i_align.sv
module f2i_align #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter int INT_W  = 32
) (
  input  logic [EXP_W-1:0] exp_f,
  input  logic [FRAC_W:0]  sig,
  output logic [INT_W-1:0] whole,
  output logic [INT_W-1:0] frac_part
);
  localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
  localparam int FIX_W   = 2 * INT_W;
  localparam int SH_W    = $clog2(FIX_W);
  localparam int SH_BASE = BIAS + FRAC_W - INT_W;
  localparam int SH_MIN  = INT_W - FRAC_W - 1;
  localparam int SH_MAX  = 2 * INT_W - 1 - FRAC_W;

  int               sh_i;
  logic [SH_W-1:0]  sh_u;
  logic [FIX_W-1:0] fixed;

  // Fixed point image: upper half integer, lower half fraction
  always_comb begin
    sh_i = int'(exp_f) - SH_BASE;
    if (sh_i >= SH_MIN && sh_i <= SH_MAX) sh_u = SH_W'(sh_i);
    else                                  sh_u = '0;
    fixed = FIX_W'(sig) << sh_u;
  end

  assign whole     = fixed[FIX_W-1:INT_W];
  assign frac_part = fixed[INT_W-1:0];
endmodule

// File: rtl/f2i_round_dec.sv
module f2i_round_dec #(
  parameter int INT_W = 32
) (
  input  f2i_pkg::rmode_e  mode,
  input  logic             neg,
  input  logic             lsb,
  input  logic [INT_W-1:0] rem,
  output logic             bump
);
  import f2i_pkg::*;

  function automatic logic decide(rmode_e m, logic n, logic l, logic [INT_W-1:0] r);
    logic [INT_W-1:0] half;
    logic             any;
    half = {1'b1, {(INT_W-1){1'b0}}};
    any  = |r;
    case (m)
      RM_NEAREST: decide = (r > half) || (r == half && l);
      RM_POS:     decide = any && !n;
      RM_NEG:     decide = any && n;
      default:    decide = 1'b0;
    endcase
  endfunction

  assign bump = decide(mode, neg, lsb, rem);
endmodule

// File: rtl/f2i_convert.sv
module f2i_convert #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter int INT_W  = 32
) (
  input  logic [EXP_W+FRAC_W:0] op_bits,
  input  logic                  want_signed,
  input  logic [1:0]            rnd_mode,
  input  logic                  force_trunc,
  output logic [INT_W-1:0]      int_out,
  output logic                  flag_invalid,
  output logic                  flag_inexact,
  output logic                  flag_denorm
);
  import f2i_pkg::*;

  localparam int BIAS = (1 << (EXP_W - 1)) - 1;
  localparam logic [EXP_W-1:0] E_SAT = EXP_W'(BIAS + INT_W);
  localparam logic [EXP_W-1:0] E_LOW = EXP_W'(BIAS - 1);
  localparam logic [INT_W-1:0] S_MAX = {1'b0, {(INT_W-1){1'b1}}};
  localparam logic [INT_W-1:0] S_MIN = {1'b1, {(INT_W-1){1'b0}}};

  fclass_t          cls;
  logic             op_neg;
  logic [EXP_W-1:0] exp_f;
  logic [FRAC_W:0]  sig;
  logic [INT_W-1:0] whole;
  logic [INT_W-1:0] frac_part;
  rmode_e           eff_mode;

  // Named events for the checker
  logic path_nan, path_sat, path_tiny, path_mid;
  logic rnd_bump, carry_lost, neg_hit, clamp_hit, has_frac;
  logic tiny_nz, tiny_up, tiny_dn;
  logic [INT_W-1:0] whole_r;
  logic [INT_W-1:0] lim;

  f2i_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
    .op_bits(op_bits), .cls(cls), .op_neg(op_neg), .exp_f(exp_f), .sig(sig)
  );

  f2i_align #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .INT_W(INT_W)) u_align (
    .exp_f(exp_f), .sig(sig), .whole(whole), .frac_part(frac_part)
  );

  assign eff_mode = force_trunc ? RM_ZERO : rmode_e'(rnd_mode);

  f2i_round_dec #(.INT_W(INT_W)) u_rnd (
    .mode(eff_mode), .neg(op_neg), .lsb(whole[0]), .rem(frac_part), .bump(rnd_bump)
  );

  // Range paths
  assign path_nan  = cls.is_nan;
  assign path_sat  = !cls.is_nan && (cls.is_inf || exp_f >= E_SAT);
  assign path_tiny = exp_f < E_LOW;
  assign path_mid  = !path_nan && !path_sat && !path_tiny;

  // In-range rounding and limits
  assign carry_lost = rnd_bump && (&whole);
  assign whole_r    = (rnd_bump && !(&whole)) ? whole + 1'b1 : whole;
  assign has_frac   = |frac_part;
  assign neg_hit    = op_neg && (|whole_r);
  assign lim        = op_neg ? S_MIN : S_MAX;
  assign clamp_hit  = whole_r > lim;

  // Small magnitudes
  assign tiny_nz = !cls.is_zero;
  assign tiny_up = tiny_nz && !op_neg && eff_mode == RM_POS;
  assign tiny_dn = tiny_nz && op_neg && eff_mode == RM_NEG;

  always_comb begin
    int_out      = '0;
    flag_invalid = 1'b0;
    flag_inexact = 1'b0;
    if (path_nan) begin
      int_out      = want_signed ? '0 : '1;
      flag_invalid = 1'b1;
    end else if (path_sat) begin
      if (want_signed) int_out = op_neg ? S_MIN : S_MAX;
      else             int_out = op_neg ? '0 : '1;
      flag_invalid = 1'b1;
    end else if (path_tiny) begin
      flag_inexact = tiny_nz;
      if (tiny_up) begin
        int_out = INT_W'(1);
      end else if (tiny_dn) begin
        if (want_signed) int_out = '1;
        else             flag_invalid = 1'b1;
      end
    end else if (want_signed) begin
      if (clamp_hit) begin
        int_out      = lim;
        flag_invalid = 1'b1;
      end else begin
        int_out      = op_neg ? (~whole_r + 1'b1) : whole_r;
        flag_inexact = has_frac;
      end
    end else begin
      if (neg_hit) begin
        flag_invalid = 1'b1;
      end else begin
        int_out      = whole_r;
        flag_invalid = carry_lost;
        flag_inexact = has_frac && !carry_lost;
      end
    end
  end

  assign flag_denorm = cls.is_sub;
endmodule

// File: rtl/f2i_convert_chk.sv
module f2i_convert_chk #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter int INT_W  = 32
) (
  input logic [EXP_W+FRAC_W:0] op_bits,
  input logic                  want_signed,
  input logic                  force_trunc,
  input logic [INT_W-1:0]      int_out,
  input logic                  flag_invalid,
  input logic                  flag_inexact,
  input logic                  flag_denorm,
  input logic                  path_nan,
  input logic                  path_sat,
  input logic                  path_tiny,
  input logic                  path_mid,
  input logic                  rnd_bump
);
  localparam int IN_W = 1 + EXP_W + FRAC_W;

  logic in_neg;
  logic in_zero;
  assign in_neg  = op_bits[IN_W-1];
  assign in_zero = ~|op_bits[IN_W-2:0];

  always_comb begin
    assert_one_path_R4: assert ($countones({path_nan, path_sat, path_tiny, path_mid}) == 1);
    if (in_zero)
      assert_zero_quiet_R1: assert (int_out == '0 && !flag_invalid && !flag_inexact && !flag_denorm);
    if (flag_denorm)
      assert_denorm_small_R2: assert (int_out == '0 || int_out == INT_W'(1) || int_out == '1);
    if (path_nan)
      assert_nan_invalid_R3: assert (flag_invalid && !flag_inexact);
    if (path_sat)
      assert_sat_invalid_R4: assert (flag_invalid && !flag_inexact);
    if (force_trunc)
      assert_trunc_no_bump_R10: assert (!rnd_bump);
    if (want_signed && !path_nan && int_out != '0)
      assert_signed_sign_R7: assert (int_out[INT_W-1] == in_neg);
    if (!want_signed && in_neg && !path_nan)
      assert_unsigned_neg_R6: assert (int_out == '0);
    if (flag_invalid && flag_inexact)
      assert_flag_pair_R8: assert (path_tiny && !want_signed && in_neg);
  end
endmodule

bind f2i_convert f2i_convert_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .INT_W(INT_W)) u_chk (
  .op_bits(op_bits), .want_signed(want_signed), .force_trunc(force_trunc),
  .int_out(int_out), .flag_invalid(flag_invalid), .flag_inexact(flag_inexact),
  .flag_denorm(flag_denorm), .path_nan(path_nan), .path_sat(path_sat),
  .path_tiny(path_tiny), .path_mid(path_mid), .rnd_bump(rnd_bump)
);

// File: tb/f2i_convert_bench.sv
module f2i_convert_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] op_bits = '0;
  logic        want_signed = 1'b0;
  logic [1:0]  rnd_mode = 2'b00;
  logic        force_trunc = 1'b0;
  logic [31:0] int_out;
  logic        flag_invalid, flag_inexact, flag_denorm;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  f2i_convert u_f2i_convert (
    .op_bits(op_bits), .want_signed(want_signed), .rnd_mode(rnd_mode),
    .force_trunc(force_trunc), .int_out(int_out), .flag_invalid(flag_invalid),
    .flag_inexact(flag_inexact), .flag_denorm(flag_denorm)
  );

  // Reference model built on real arithmetic; returns {value, inv, inx, den}
  function automatic logic [34:0] model(logic [31:0] x, logic sgn, logic [1:0] rm_in, logic ft);
    int         e;
    logic [22:0] f;
    logic       neg, up;
    logic [1:0] rm;
    real        a, tr, fr, r, lim;
    logic [31:0] v;
    logic       inv, inx, den;
    neg = x[31]; e = int'(x[30:23]); f = x[22:0];
    rm  = ft ? 2'b11 : rm_in;
    den = (e == 0) && (f != 0);
    inv = 0; inx = 0; v = '0;
    if (e == 255 && f != 0) begin
      v = sgn ? 32'h0 : 32'hFFFF_FFFF; inv = 1;
    end else if (e == 0 && f == 0) begin
      v = '0;
    end else begin
      if (e == 255) a = 1.0e40;
      else if (e == 0) a = real'(f) * (2.0 ** (-149.0));
      else a = (8388608.0 + real'(f)) * (2.0 ** real'(e - 150));
      tr = $floor(a); fr = a - tr;
      case (rm)
        2'b00: up = (fr > 0.5) || (fr == 0.5 && (longint'(tr) % 2 == 1));
        2'b01: up = !neg && fr != 0.0;
        2'b10: up = neg && fr != 0.0;
        default: up = 0;
      endcase
      r = tr + (up ? 1.0 : 0.0);
      if (!sgn) begin
        if (!neg) begin
          if (r > 4294967295.0) begin v = 32'hFFFF_FFFF; inv = 1; end
          else begin v = 32'(longint'(r)); inx = fr != 0.0; end
        end else if (r == 0.0) begin
          inx = fr != 0.0;
        end else begin
          inv = 1; inx = a < 0.5;
        end
      end else begin
        lim = neg ? 2147483648.0 : 2147483647.0;
        if (r > lim) begin v = neg ? 32'h8000_0000 : 32'h7FFF_FFFF; inv = 1; end
        else begin
          v = neg ? 32'(-longint'(r)) : 32'(longint'(r));
          inx = fr != 0.0;
        end
      end
    end
    return {v, inv, inx, den};
  endfunction

  task automatic apply(string tag, logic [31:0] x, logic sgn, logic [1:0] rm, logic ft);
    logic [34:0] exp_v;
    @(negedge clk);
    op_bits = x; want_signed = sgn; rnd_mode = rm; force_trunc = ft;
    @(posedge clk); #1;
    exp_v = model(x, sgn, rm, ft);
    checks++;
    if ({int_out, flag_invalid, flag_inexact, flag_denorm} !== exp_v) begin
      fails++;
      $display("FAIL %s in=%h signed=%0b mode=%0d trunc=%0b got %h inv%0b inx%0b den%0b expected %h inv%0b inx%0b den%0b",
               tag, x, sgn, rm, ft, int_out, flag_invalid, flag_inexact, flag_denorm,
               exp_v[34:3], exp_v[2], exp_v[1], exp_v[0]);
    end
  endtask

  function automatic string tag_of(logic [31:0] x, logic sgn, logic ft);
    int e;
    e = int'(x[30:23]);
    if (e == 255 && x[22:0] != 0) return "R3";
    if (x[30:0] == 0) return "R1";
    if (e == 0) return "R2";
    if (e >= 159) return "R4";
    if (e < 126) return "R9";
    if (ft) return "R10";
    if (!sgn && x[31]) return "R6";
    if (sgn) return "R7";
    return "R5";
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired before R1..R10 stimulus finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] x;
    logic [7:0]  e;
    logic        s, ft;
    logic [1:0]  rm;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R1 reset state and zero inputs
    apply("R1", 32'h0000_0000, 1'b1, 2'b00, 1'b0);
    apply("R1", 32'h8000_0000, 1'b0, 2'b10, 1'b0);
    // R2 subnormals with directed rounding
    apply("R2", 32'h0000_0001, 1'b1, 2'b01, 1'b0);
    apply("R2", 32'h8040_0000, 1'b1, 2'b10, 1'b0);
    apply("R2", 32'h8000_0010, 1'b0, 2'b10, 1'b0);
    // R3 NaNs
    apply("R3", 32'h7FC0_0000, 1'b0, 2'b00, 1'b0);
    apply("R3", 32'h7FC0_0000, 1'b1, 2'b00, 1'b0);
    apply("R3", 32'hFF80_0001, 1'b0, 2'b01, 1'b0);
    // R4 saturation
    apply("R4", 32'h4F80_0000, 1'b0, 2'b00, 1'b0);
    apply("R4", 32'hCF80_0000, 1'b0, 2'b00, 1'b0);
    apply("R4", 32'hCF80_0000, 1'b1, 2'b00, 1'b0);
    apply("R4", 32'h7F80_0000, 1'b1, 2'b00, 1'b0);
    apply("R4", 32'hFF80_0000, 1'b0, 2'b11, 1'b0);
    // R5 rounding modes and ties
    apply("R5", 32'h4020_0000, 1'b1, 2'b00, 1'b0);
    apply("R5", 32'h4060_0000, 1'b1, 2'b00, 1'b0);
    apply("R5", 32'h4020_0000, 1'b0, 2'b01, 1'b0);
    apply("R5", 32'hC020_0000, 1'b1, 2'b10, 1'b0);
    apply("R5", 32'h4020_0000, 1'b1, 2'b11, 1'b0);
    apply("R5", 32'h4F7F_FFFF, 1'b0, 2'b01, 1'b0);
    // R6 negative into unsigned
    apply("R6", 32'hBF80_0000, 1'b0, 2'b00, 1'b0);
    apply("R6", 32'hBF40_0000, 1'b0, 2'b11, 1'b0);
    apply("R6", 32'hBF40_0000, 1'b0, 2'b00, 1'b0);
    // R7 signed clamp edges
    apply("R7", 32'h4F00_0000, 1'b1, 2'b00, 1'b0);
    apply("R7", 32'hCF00_0000, 1'b1, 2'b00, 1'b0);
    apply("R7", 32'h4EFF_FFFF, 1'b1, 2'b01, 1'b0);
    apply("R7", 32'hCF00_0001, 1'b1, 2'b00, 1'b0);
    // R8 inexact without clamp
    apply("R8", 32'h3FC0_0000, 1'b0, 2'b11, 1'b0);
    apply("R8", 32'h3FC0_0000, 1'b1, 2'b10, 1'b0);
    // R9 tiny magnitudes
    apply("R9", 32'h3E80_0000, 1'b0, 2'b01, 1'b0);
    apply("R9", 32'hBE80_0000, 1'b1, 2'b10, 1'b0);
    apply("R9", 32'hBE80_0000, 1'b0, 2'b10, 1'b0);
    apply("R9", 32'h3E80_0000, 1'b1, 2'b00, 1'b0);
    // R10 forced truncation
    apply("R10", 32'h4020_0000, 1'b0, 2'b01, 1'b1);
    apply("R10", 32'hBE80_0000, 1'b1, 2'b10, 1'b1);
    apply("R10", 32'h4060_0000, 1'b1, 2'b00, 1'b1);
    // Constrained random
    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++) begin
      case ($urandom_range(0, 7))
        0:       e = 8'd0;
        1:       e = 8'd255;
        2:       e = 8'($urandom_range(124, 127));
        3:       e = 8'($urandom_range(156, 160));
        default: e = 8'($urandom_range(100, 170));
      endcase
      s  = 1'($urandom_range(0, 1));
      x  = {s, e, 23'($urandom)};
      if ($urandom_range(0, 15) == 0) x[22:0] = '0;
      rm = 2'($urandom_range(0, 3));
      ft = ($urandom_range(0, 7) == 0);
      s  = 1'($urandom_range(0, 1));
      apply(tag_of(x, s, ft), x, s, rm, ft);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule